// File: doc/BRIEF.md
# Display Timing and CPU Register Window

This block generates the raster timing for a 256x240 picture. One frame has 262 scanlines of 341 dots each. A dot counter and a scanline counter advance on a dot-clock enable. The block raises a vertical-blank flag on a fixed scanline and clears it again on the pre-render line. From that flag and an interrupt-enable control bit it produces an interrupt request.

The same block decodes an 8-entry CPU register window: a 3-bit select, separate read and write strobes, and a data byte. Control and mode bytes are stored and driven out to the rendering logic.

The scroll and VRAM-address registers are each loaded by two consecutive writes. A single write-phase toggle, shared by both registers, steers each write. Reading the status register returns the vertical-blank and sprite flags. That read also clears the vertical-blank flag and resets the shared toggle. Sprite-0 hit and sprite overflow are set by one-cycle pulses from the renderer and are held until the pre-render line.

Top module: `vid_timing_regs`

## Requirements
- R1: After reset, both counters, the vertical-blank flag, the interrupt output, the sprite flags, the write toggle, the control and mode bytes, both scroll bytes and the VRAM address are all zero.
- R2: The dot counter advances only in cycles where `dot_en_i` is high. It counts 0..340; the dot after 340 is 0 and moves the scanline counter on by one. The scanline counter counts 0..261 and wraps to 0.
- R3: The vertical-blank flag becomes 1 in the enabled cycle that enters scanline 241, dot 0, and not before.
- R4: The vertical-blank flag, sprite-0 hit and sprite overflow become 0 in the enabled cycle that enters scanline 261, dot 0.
- R5: While `bus_sel_i` = 2, `bus_rdata_o` is {vblank, sprite-0 hit, overflow, 5'b0}, with vblank in bit 7. A read strobe at select 2 clears the vertical-blank flag on that edge and leaves the sprite flags unchanged.
- R6: A one-cycle pulse on `spr0_hit_i` or `spr_ovf_i` sets the corresponding sticky flag.
- R7: `nmi_o` is high exactly when the vertical-blank flag and bit 7 of the control byte are both 1. Setting that bit during vertical blank raises `nmi_o` on the edge of the write.
- R8: Writes to select 5 load scroll X when the toggle is 0 and scroll Y when it is 1. Writes to select 6 load the address high byte when the toggle is 0 and the low byte when it is 1. Every write to select 5 or 6 inverts the shared toggle.
- R9: A read strobe at select 2 resets the shared toggle to 0, so the next write to select 5 or 6 is a first write.
- R10: Writes to select 0 and 1 load `ctrl_o` and `mask_o`. Writes to selects 2, 3, 4 and 7 change no output and do not alter the toggle. Reads at any select other than 2 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_en_i | input | 1 | Dot-clock enable, advances timing |
| bus_sel_i | input | 3 | Register select |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current select |
| spr0_hit_i | input | 1 | Sprite-0 hit set pulse |
| spr_ovf_i | input | 1 | Sprite overflow set pulse |
| dot_o | output | 9 | Current dot within the scanline |
| line_o | output | 9 | Current scanline |
| vblank_o | output | 1 | Vertical-blank flag |
| nmi_o | output | 1 | Interrupt request, active high |
| ctrl_o | output | 8 | Stored control byte |
| mask_o | output | 8 | Stored mode byte |
| scroll_x_o | output | 8 | Latched horizontal scroll |
| scroll_y_o | output | 8 | Latched vertical scroll |
| vaddr_o | output | 16 | Latched VRAM address |

## Verification
The hardest states to reach are the two raster boundaries, entry to line 241 and entry to line 261. Each lies tens of thousands of enabled dots from reset.

The stimulus first walks the register tests with the dot enable held low, so the counters stay frozen at zero. It then holds the enable high and runs the raster through one full frame and into the next vertical blank. It stops one dot before each boundary to check the flag's old value and again on the boundary itself.

The second vertical blank is kept for the clearing read. This means the flag reaches line 261 still set in the first frame, so the pre-render clear is seen on a flag that was actually high.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_SPADR = 3'd3,
    SEL_SPDAT = 3'd4,
    SEL_SCRL  = 3'd5,
    SEL_VADR  = 3'd6,
    SEL_VDAT  = 3'd7
  } vt_sel_e;

  localparam int STAT_VBL_BIT = 7;
  localparam int STAT_HIT_BIT = 6;
  localparam int STAT_OVF_BIT = 5;
  localparam int CTRL_NMI_BIT = 7;
endpackage

// File: rtl/vt_timing.sv
module vt_timing #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int CW       = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dot_en_i,
  output logic [CW-1:0] dot_o,
  output logic [CW-1:0] line_o,
  output logic          vbl_set_o,
  output logic          vbl_clr_o
);
  localparam logic [CW-1:0] LAST_DOT  = CW'(DOTS - 1);
  localparam logic [CW-1:0] LAST_LINE = CW'(LINES - 1);
  localparam logic [CW-1:0] PRE_VBL   = CW'(VBL_LINE - 1);
  localparam logic [CW-1:0] PRE_PRE   = CW'(PRE_LINE - 1);

  logic [CW-1:0] dot_q, line_q;
  logic          end_of_line;

  assign end_of_line = (dot_q == LAST_DOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (dot_en_i) begin
      if (end_of_line) begin
        dot_q  <= '0;
        line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
      end else begin
        dot_q <= dot_q + 1'b1;
      end
    end
  end

  // one-cycle pulses on the enabled edge that enters the boundary line
  assign vbl_set_o = dot_en_i && end_of_line && (line_q == PRE_VBL);
  assign vbl_clr_o = dot_en_i && end_of_line && (line_q == PRE_PRE);

  assign dot_o  = dot_q;
  assign line_o = line_q;

  // R2
  dot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_q <= LAST_DOT) && (line_q <= LAST_LINE));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> ($stable(dot_q) && $stable(line_q)));
endmodule

// File: rtl/vt_status.sv
module vt_status #(
  parameter int CW       = 9,
  parameter int VBL_LINE = 241
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vbl_set_i,
  input  logic          vbl_clr_i,
  input  logic          stat_rd_i,
  input  logic          hit_set_i,
  input  logic          ovf_set_i,
  input  logic [CW-1:0] dot_i,
  input  logic [CW-1:0] line_i,
  output logic          vblank_o,
  output logic          hit_o,
  output logic          ovf_o
);
  logic vbl_q, hit_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbl_q <= 1'b0;
      hit_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      // set wins over a coincident status read
      if (vbl_set_i)                  vbl_q <= 1'b1;
      else if (vbl_clr_i || stat_rd_i) vbl_q <= 1'b0;
      if (vbl_clr_i)      hit_q <= 1'b0;
      else if (hit_set_i) hit_q <= 1'b1;
      if (vbl_clr_i)      ovf_q <= 1'b0;
      else if (ovf_set_i) ovf_q <= 1'b1;
    end
  end

  assign vblank_o = vbl_q;
  assign hit_o    = hit_q;
  assign ovf_o    = ovf_q;

  // R3
  vbl_entry_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vbl_q) |-> (line_i == CW'(VBL_LINE) && dot_i == '0));
  // R4
  prerender_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbl_clr_i |=> (!vbl_q && !hit_q && !ovf_q));
  // R5
  read_clears_vbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !vbl_set_i) |=> !vbl_q);
  // R6
  hit_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set_i && !vbl_clr_i) |=> hit_q);
endmodule

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        wdata_i,
  output logic              stat_rd_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        scroll_x_o,
  output logic [7:0]        scroll_y_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  logic [7:0]        ctrl_q, mask_q, sx_q, sy_q;
  logic [ADDR_W-1:0] va_q;
  logic              tog_q;
  vt_sel_e           sel;

  assign sel       = vt_sel_e'(sel_i);
  assign stat_rd_o = rd_i && (sel == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      sx_q   <= '0;
      sy_q   <= '0;
      va_q   <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        case (sel)
          SEL_CTRL: ctrl_q <= wdata_i;
          SEL_MASK: mask_q <= wdata_i;
          SEL_SCRL: begin
            if (tog_q) sy_q <= wdata_i;
            else       sx_q <= wdata_i;
            tog_q <= ~tog_q;
          end
          SEL_VADR: begin
            if (tog_q) va_q[7:0]        <= wdata_i;
            else       va_q[ADDR_W-1:8] <= wdata_i[ADDR_W-9:0];
            tog_q <= ~tog_q;
          end
          default: ;
        endcase
      end
      if (stat_rd_o) tog_q <= 1'b0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign mask_o     = mask_q;
  assign scroll_x_o = sx_q;
  assign scroll_y_o = sy_q;
  assign vaddr_o    = va_q;

  // R9
  read_resets_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_o |=> !tog_q);
  // R8
  first_write_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_SCRL && !tog_q && !rd_i) |=> ($stable(sy_q) && tog_q));
  // R8
  second_write_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_VADR && tog_q && !rd_i) |=> ($stable(va_q[ADDR_W-1:8]) && !tog_q));
endmodule

// File: rtl/vid_timing_regs.sv
module vid_timing_regs
  import vt_pkg::*;
#(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int ADDR_W   = 16,
  localparam int CNT_W   = $clog2((DOTS > LINES) ? DOTS : LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dot_en_i,
  input  logic [2:0]        bus_sel_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              spr0_hit_i,
  input  logic              spr_ovf_i,
  output logic [CNT_W-1:0]  dot_o,
  output logic [CNT_W-1:0]  line_o,
  output logic              vblank_o,
  output logic              nmi_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        scroll_x_o,
  output logic [7:0]        scroll_y_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  logic vbl_set, vbl_clr, stat_rd, vbl, hit, ovf;
  logic [CNT_W-1:0] dot_w, line_w;
  logic [7:0]       ctrl_w;

  vt_timing #(
    .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .CW(CNT_W)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .dot_en_i(dot_en_i),
    .dot_o(dot_w), .line_o(line_w), .vbl_set_o(vbl_set), .vbl_clr_o(vbl_clr)
  );

  vt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .sel_i(bus_sel_i), .wdata_i(bus_wdata_i), .stat_rd_o(stat_rd),
    .ctrl_o(ctrl_w), .mask_o(mask_o), .scroll_x_o(scroll_x_o),
    .scroll_y_o(scroll_y_o), .vaddr_o(vaddr_o)
  );

  vt_status #(.CW(CNT_W), .VBL_LINE(VBL_LINE)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .vbl_set_i(vbl_set), .vbl_clr_i(vbl_clr),
    .stat_rd_i(stat_rd), .hit_set_i(spr0_hit_i), .ovf_set_i(spr_ovf_i),
    .dot_i(dot_w), .line_i(line_w),
    .vblank_o(vbl), .hit_o(hit), .ovf_o(ovf)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i == SEL_STAT) begin
      bus_rdata_o[STAT_VBL_BIT] = vbl;
      bus_rdata_o[STAT_HIT_BIT] = hit;
      bus_rdata_o[STAT_OVF_BIT] = ovf;
    end
  end

  assign nmi_o    = vbl & ctrl_w[CTRL_NMI_BIT];
  assign vblank_o = vbl;
  assign ctrl_o   = ctrl_w;
  assign dot_o    = dot_w;
  assign line_o   = line_w;

  // R7
  nmi_follows_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbl && !stat_rd && !vbl_clr && bus_wr_i && bus_sel_i == SEL_CTRL && bus_wdata_i[CTRL_NMI_BIT])
      |=> nmi_o);
endmodule

// File: tb/vid_timing_regs_bench.sv
module vid_timing_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dot_en = 1'b0;
  logic [2:0]  sel = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit_p = 1'b0, ovf_p = 1'b0;
  logic [8:0]  dot, line;
  logic        vblank, nmi;
  logic [7:0]  ctrl, mask, sx, sy;
  logic [15:0] vaddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vid_timing_regs u_vid_timing_regs (
    .clk_i(clk), .rst_ni(rst_n), .dot_en_i(dot_en),
    .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .spr0_hit_i(hit_p), .spr_ovf_i(ovf_p),
    .dot_o(dot), .line_o(line), .vblank_o(vblank), .nmi_o(nmi),
    .ctrl_o(ctrl), .mask_o(mask), .scroll_x_o(sx), .scroll_y_o(sy), .vaddr_o(vaddr)
  );

  typedef struct packed {
    logic [2:0]  s;
    logic [7:0]  d;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [15:0] a;
  } vec_t;

  // R8 / R10: write sequence with expected scroll and address after each write
  localparam vec_t VEC [0:11] = '{
    '{3'd5, 8'h12, 8'h12, 8'h00, 16'h0000},
    '{3'd5, 8'h34, 8'h12, 8'h34, 16'h0000},
    '{3'd6, 8'h3F, 8'h12, 8'h34, 16'h3F00},
    '{3'd6, 8'h10, 8'h12, 8'h34, 16'h3F10},
    '{3'd5, 8'hAB, 8'hAB, 8'h34, 16'h3F10},
    '{3'd6, 8'h21, 8'hAB, 8'h34, 16'h3F21},
    '{3'd6, 8'h07, 8'hAB, 8'h34, 16'h0721},
    '{3'd3, 8'hFF, 8'hAB, 8'h34, 16'h0721},
    '{3'd2, 8'hFF, 8'hAB, 8'h34, 16'h0721},
    '{3'd4, 8'hEE, 8'hAB, 8'h34, 16'h0721},
    '{3'd7, 8'hDD, 8'hAB, 8'h34, 16'h0721},
    '{3'd5, 8'h56, 8'hAB, 8'h56, 16'h0721}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    sel = s; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_flag(input bit which_ovf);
    @(negedge clk);
    if (which_ovf) ovf_p = 1'b1; else hit_p = 1'b1;
    @(negedge clk);
    hit_p = 1'b0; ovf_p = 1'b0;
  endtask

  task automatic run_to(input int l, input int d);
    while (!(line == 9'(l) && dot == 9'(d))) @(negedge clk);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 counters", {line, dot}, 0);
    check("R1 flags", {vblank, nmi}, 0);
    check("R1 regs", {ctrl, mask, sx, sy, vaddr[7:0]}, 0);
    check("R1 vaddr hi", vaddr, 0);

    for (int i = 0; i < 12; i++) begin
      bus_write(VEC[i].s, VEC[i].d);
      check($sformatf("R8/R10 vec %0d", i), {sx, sy, vaddr}, {VEC[i].x, VEC[i].y, VEC[i].a});
    end
    check("R10 ignored writes ctrl/mask", {ctrl, mask}, 0);

    // R9: status read resets toggle mid-pair
    bus_write(3'd5, 8'h11);
    check("R9 first write x", sx, 8'h11);
    bus_read(3'd2, r);
    check("R5 status idle", r, 8'h00);
    bus_write(3'd5, 8'h22);
    check("R9 restart x", {sx, sy}, {8'h22, 8'h56});

    // R10 control and mode
    bus_write(3'd0, 8'h80);
    bus_write(3'd1, 8'h1E);
    check("R10 ctrl/mask", {ctrl, mask}, {8'h80, 8'h1E});
    check("R7 no nmi outside vblank", nmi, 0);
    bus_read(3'd0, r); check("R10 read sel0", r, 0);
    bus_read(3'd3, r); check("R10 read sel3", r, 0);
    bus_read(3'd4, r); check("R10 read sel4", r, 0);
    bus_read(3'd7, r); check("R10 read sel7", r, 0);

    // R6 sticky flags, R5 read leaves them
    pulse_flag(1'b0);
    bus_read(3'd2, r); check("R6 hit", r, 8'h40);
    pulse_flag(1'b1);
    bus_read(3'd2, r); check("R6 ovf", r, 8'h60);
    bus_read(3'd2, r); check("R5 sprite flags kept", r, 8'h60);

    // R2: frozen while enable low
    check("R2 frozen", {line, dot}, 0);

    @(negedge clk); dot_en = 1'b1;
    @(negedge clk);
    check("R2 first advance", {line, dot}, {9'd0, 9'd1});
    run_to(0, 340);
    @(negedge clk);
    check("R2 dot wrap", {line, dot}, {9'd1, 9'd0});

    run_to(240, 340);
    check("R3 before entry", vblank, 0);
    @(negedge clk);
    check("R3 entry pos", {line, dot}, {9'd241, 9'd0});
    check("R3 vblank set", vblank, 1);
    check("R7 nmi on entry", nmi, 1);
    bus_write(3'd0, 8'h00);
    check("R7 nmi off", nmi, 0);
    bus_write(3'd0, 8'h80);
    check("R7 nmi immediate", nmi, 1);

    run_to(260, 340);
    check("R4 still set", vblank, 1);
    @(negedge clk);
    check("R4 vblank cleared", {vblank, nmi}, 0);
    @(negedge clk); dot_en = 1'b0;
    bus_read(3'd2, r); check("R4 sprite flags cleared", r, 8'h00);
    @(negedge clk); dot_en = 1'b1;

    run_to(261, 340);
    @(negedge clk);
    check("R2 frame wrap", {line, dot}, 0);

    pulse_flag(1'b0);
    run_to(241, 0);
    check("R3 second frame", vblank, 1);
    @(negedge clk); dot_en = 1'b0;
    bus_read(3'd2, r); check("R5 status in vblank", r, 8'hC0);
    check("R5 vblank cleared by read", {vblank, nmi}, 0);
    bus_read(3'd2, r); check("R5 hit survives read", r, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule